// File: doc/BRIEF.md
# I2C Slave Transmitter Controller

This block is the read-side slave half of a status-driven I2C controller. It watches the SCL and SDA lines through synchronizers, finds START and STOP conditions, compares each address byte against a 7-bit own address with the read bit set, and then sends bytes to the master that is reading. After every event that needs a decision, it posts an 8-bit status code, raises an interrupt flag, and holds SCL low. It stays that way until software answers with one control write. That write carries the next byte plus the AA and STA bits, and it clears the flag.

Software steers every byte. A byte supplied with AA=1 expects the master to acknowledge and ask for more. A byte supplied with AA=0 is the final one. When the master stops acknowledging, or the final byte has gone out, the block posts an exit status. The control write that answers an exit status decides two things: whether the own address is acknowledged again, and whether a START request goes to the master engine once the bus is free. A control write made while no flag is pending updates only the recognition enable. An external master engine reports lost arbitration on a one-cycle input. Write-direction addresses, including the general call, belong to the receive half and are never acknowledged here.

Top module: `i2c_slv_tx`

## Requirements
- R1: Own address with R/W bit 1, while recognition is enabled, is acknowledged (SDA low during the ninth clock). After the ninth SCL fall the block raises `irq`, posts status 0xA8 and holds SCL low.
- R2: If `arb_lost` pulsed after the START and before the address is matched, the acknowledged own read address posts 0xB0 instead of 0xA8.
- R3: Data bytes leave most significant bit first. SDA changes only while SCL is low, and the first bit is on SDA before SCL is released.
- R4: A byte supplied with AA=1 that the master acknowledges (SDA low on the ninth rising edge) posts 0xB8.
- R5: A byte that the master does not acknowledge posts 0xC0.
- R6: A byte supplied with AA=0 that the master still acknowledges posts 0xC8.
- R7: While `irq` is 1, SCL is held low. A control write clears `irq` and releases SCL. `status` reads 0xF8 whenever `irq` is 0.
- R8: The control write answering 0xC0 or 0xC8 returns the block to not-addressed mode. With AA=0 the own address is then not acknowledged and `irq` stays 0. With AA=1 it is acknowledged again.
- R9: STA=1 in the control write answering 0xC0 or 0xC8 produces exactly one `start_go` pulse. The pulse comes only after the next STOP frees the bus, never before.
- R10: A non-matching address, or the own address with R/W bit 0, is not acknowledged and does not raise `irq`.
- R11: After reset `irq` is 0, `status` is 0xF8 and neither line is driven. A STOP in the middle of a byte returns the block to not-addressed mode with SDA released.
- R12: A control write while `irq` is 0 sets the address recognition enable from AA. Recognition is enabled out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (open-drain) |
| sda_drive_low | output | 1 | Pull SDA low (open-drain) |
| own_addr | input | 7 | Own slave address |
| arb_lost | input | 1 | One-cycle pulse from the master engine: arbitration lost |
| ctl_write | input | 1 | One-cycle software control write |
| ctl_data | input | 8 | Next byte to transmit |
| ctl_aa | input | 1 | Acknowledge/recognition control bit |
| ctl_sta | input | 1 | Queue a START for when the bus is free |
| irq | output | 1 | Interrupt flag: a status is waiting |
| status | output | 8 | Posted status code, 0xF8 when none |
| start_go | output | 1 | One-cycle request to the master engine to issue START |

## Verification
The assertions assume an electrically consistent bus. START and STOP are only seen while the block itself is not pulling SDA low. SCL stays low for the synchronizer delay after each falling edge, so that SDA updates and the ninth-clock release happen while SCL is low. The bench master meets this by holding each SCL half period for twelve clocks, well beyond the three-cycle detection delay. It waits for SCL to go high after every release, honouring the stretch, and only moves SDA while SCL is low, except when it deliberately forms START and STOP. Software writes come only while a flag is pending, or while the block is idle for the recognition tests.

// File: rtl/i2c_slv_tx_pkg.sv
`timescale 1ns/1ps
package i2c_slv_tx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [7:0] {
        ST_OWN_READ  = 8'hA8,
        ST_ARB_READ  = 8'hB0,
        ST_BYTE_ACK  = 8'hB8,
        ST_BYTE_NACK = 8'hC0,
        ST_LAST_ACK  = 8'hC8,
        ST_NONE      = 8'hF8
    } stat_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_AACK, PH_HOLD, PH_SETUP, PH_DATA, PH_MACK, PH_SKIP
    } phase_e;

    typedef enum logic [2:0] {
        TX_NOP, TX_LOAD, TX_SHIFT, TX_REL, TX_ACK
    } tx_op_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic bus_free;
    } line_t;

    function automatic logic stat_more(stat_e s);
        return (s == ST_OWN_READ) || (s == ST_ARB_READ) || (s == ST_BYTE_ACK);
    endfunction

    function automatic stat_e byte_status(logic mack, logic last);
        if (!mack)
            return ST_BYTE_NACK;
        else if (last)
            return ST_LAST_ACK;
        return ST_BYTE_ACK;
    endfunction

endpackage

// File: rtl/i2c_line_watch.sv
`timescale 1ns/1ps
module i2c_line_watch
    import i2c_slv_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_in,
    input  logic  sda_in,
    output line_t line
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_q, sda_q, free_q;
    logic scl_s, sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            free_q   <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            if (line.stop)
                free_q <= 1'b1;
            else if (line.start)
                free_q <= 1'b0;
        end
    end

    always_comb begin
        line.scl      = scl_s;
        line.sda      = sda_s;
        line.scl_rise = scl_s & ~scl_q;
        line.scl_fall = ~scl_s & scl_q;
        line.start    = scl_s & scl_q & sda_q & ~sda_s;
        line.stop     = scl_s & scl_q & ~sda_q & sda_s;
        line.bus_free = free_q;
    end

endmodule

// File: rtl/i2c_byte_tx.sv
`timescale 1ns/1ps
module i2c_byte_tx
    import i2c_slv_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  tx_op_e       op,
    input  logic [W-1:0] load_data,
    input  logic         scl_now,
    output logic         drive_low
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            drive_low <= 1'b0;
        end else begin
            case (op)
                TX_LOAD: begin
                    sr        <= load_data;
                    drive_low <= ~load_data[W-1];
                end
                TX_SHIFT: begin
                    sr        <= {sr[W-2:0], 1'b0};
                    drive_low <= ~sr[W-2];
                end
                TX_REL:  drive_low <= 1'b0;
                TX_ACK:  drive_low <= 1'b1;
                default: ;
            endcase
        end
    end

    // R3: SDA output only moves while the synchronized SCL is low
    p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (rst)
        (drive_low != $past(drive_low)) |-> !$past(scl_now));

endmodule

// File: rtl/i2c_start_queue.sv
`timescale 1ns/1ps
module i2c_start_queue (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic bus_free,
    output logic go
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            go   <= 1'b0;
        end else begin
            go <= pend && bus_free;
            if (arm)
                pend <= 1'b1;
            else if (pend && bus_free)
                pend <= 1'b0;
        end
    end

    // R9: a queued START is requested as a single pulse
    p_go_single_r9: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);

endmodule

// File: rtl/i2c_slv_tx.sv
`timescale 1ns/1ps
module i2c_slv_tx
    import i2c_slv_tx_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int SYNC_STAGES  = 2,
    parameter int SETUP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              arb_lost,
    input  logic              ctl_write,
    input  logic [DATA_W-1:0] ctl_data,
    input  logic              ctl_aa,
    input  logic              ctl_sta,
    output logic              irq,
    output logic [7:0]        status,
    output logic              start_go
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2((BYTE_W > DATA_W ? BYTE_W : DATA_W) + 1);
    localparam int SU_W   = $clog2(SETUP_CYCLES + 1);

    line_t              line;
    phase_e             phase;
    stat_e              stat_q;
    tx_op_e             tx_op;
    logic [CNT_W-1:0]   cnt;
    logic [SU_W-1:0]    su_cnt;
    logic [BYTE_W-1:0]  addr_sr;
    logic [BYTE_W-1:0]  abyte_next;
    logic               irq_q, hold_q, recog_q, arb_q, last_q, mack_q;
    logic               addr_hit, q_arm;

    i2c_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .line   (line)
    );

    i2c_byte_tx #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .op        (tx_op),
        .load_data (ctl_data),
        .scl_now   (line.scl),
        .drive_low (sda_drive_low)
    );

    i2c_start_queue u_queue (
        .clk      (clk),
        .rst      (rst),
        .arm      (q_arm),
        .bus_free (line.bus_free),
        .go       (start_go)
    );

    assign abyte_next = {addr_sr[BYTE_W-2:0], line.sda};
    assign addr_hit   = recog_q && abyte_next[0] &&
                        (abyte_next[BYTE_W-1:1] == own_addr);

    // Shifter command and START queue arming
    always_comb begin
        tx_op = TX_NOP;
        q_arm = 1'b0;
        if (line.start || line.stop) begin
            tx_op = TX_REL;
        end else begin
            case (phase)
                PH_AACK: if (line.scl_fall)
                    tx_op = sda_drive_low ? TX_REL : TX_ACK;
                PH_HOLD: if (ctl_write) begin
                    if (stat_more(stat_q))
                        tx_op = TX_LOAD;
                    else
                        q_arm = ctl_sta;
                end
                PH_DATA: if (line.scl_fall)
                    tx_op = (cnt == CNT_W'(DATA_W - 1)) ? TX_REL : TX_SHIFT;
                default: ;
            endcase
        end
    end

    // Phase sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            stat_q  <= ST_NONE;
            cnt     <= '0;
            su_cnt  <= '0;
            addr_sr <= '0;
            irq_q   <= 1'b0;
            hold_q  <= 1'b0;
            recog_q <= 1'b1;
            arb_q   <= 1'b0;
            last_q  <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            if (arb_lost)
                arb_q <= 1'b1;
            if (line.stop) begin
                phase  <= PH_IDLE;
                irq_q  <= 1'b0;
                hold_q <= 1'b0;
                arb_q  <= 1'b0;
            end else if (line.start) begin
                phase  <= PH_ADDR;
                cnt    <= '0;
                irq_q  <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                case (phase)
                    PH_IDLE, PH_SKIP: begin
                        if (ctl_write)
                            recog_q <= ctl_aa;
                    end
                    PH_ADDR: begin
                        if (line.scl_rise) begin
                            addr_sr <= abyte_next;
                            cnt     <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1))
                                phase <= addr_hit ? PH_AACK : PH_SKIP;
                        end
                    end
                    PH_AACK: begin
                        if (line.scl_fall && sda_drive_low) begin
                            phase  <= PH_HOLD;
                            irq_q  <= 1'b1;
                            hold_q <= 1'b1;
                            stat_q <= arb_q ? ST_ARB_READ : ST_OWN_READ;
                            arb_q  <= 1'b0;
                        end
                    end
                    PH_HOLD: begin
                        if (ctl_write) begin
                            irq_q <= 1'b0;
                            if (stat_more(stat_q)) begin
                                phase  <= PH_SETUP;
                                su_cnt <= '0;
                                last_q <= ~ctl_aa;
                            end else begin
                                phase   <= PH_IDLE;
                                hold_q  <= 1'b0;
                                recog_q <= ctl_aa;
                            end
                        end
                    end
                    PH_SETUP: begin
                        su_cnt <= su_cnt + 1'b1;
                        if (su_cnt == SU_W'(SETUP_CYCLES - 1)) begin
                            hold_q <= 1'b0;
                            phase  <= PH_DATA;
                            cnt    <= '0;
                        end
                    end
                    PH_DATA: begin
                        if (line.scl_fall) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(DATA_W - 1))
                                phase <= PH_MACK;
                        end
                    end
                    PH_MACK: begin
                        if (line.scl_rise)
                            mack_q <= ~line.sda;
                        if (line.scl_fall) begin
                            phase  <= PH_HOLD;
                            irq_q  <= 1'b1;
                            hold_q <= 1'b1;
                            stat_q <= byte_status(mack_q, last_q);
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign irq           = irq_q;
    assign scl_drive_low = hold_q;
    assign status        = irq_q ? stat_q : ST_NONE;

    // R7: a pending flag always stretches the clock
    p_flag_stretches_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> scl_drive_low);

    // R7: the flag is only raised while SCL is low
    p_flag_rises_low_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> !line.scl);

    // R1: a raised flag carries one of the transmitter codes
    p_flag_code_legal_r1: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q == ST_OWN_READ || stat_q == ST_ARB_READ ||
                 stat_q == ST_BYTE_ACK || stat_q == ST_BYTE_NACK ||
                 stat_q == ST_LAST_ACK));

    // R8: no address acknowledge while recognition is off
    p_ack_needs_recog_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_AACK) |-> recog_q);

endmodule

// File: tb/i2c_slv_tx_bench.sv
`timescale 1ns/1ps
module i2c_slv_tx_bench;

    localparam int H = 12;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_drv, sda_drv, scl_line, sda_line;
    logic arb_lost = 1'b0, ctl_write = 1'b0, ctl_aa = 1'b0, ctl_sta = 1'b0;
    logic [7:0] ctl_data = 8'h00;
    logic irq, start_go;
    logic [7:0] status;

    assign scl_line = !(m_scl_low || scl_drv);
    assign sda_line = !(m_sda_low || sda_drv);

    i2c_slv_tx u_i2c_slv_tx (
        .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drv), .sda_drive_low(sda_drv),
        .own_addr(OWN), .arb_lost(arb_lost),
        .ctl_write(ctl_write), .ctl_data(ctl_data), .ctl_aa(ctl_aa), .ctl_sta(ctl_sta),
        .irq(irq), .status(status), .start_go(start_go)
    );

    int n_chk = 0, n_bad = 0, go_count = 0, sda_hi_moves = 0;
    bit b_recog = 1'b1, done = 1'b0;
    logic prev_sda_drv = 1'b0, prev_scl = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (start_go) go_count++;
            if (sda_drv != prev_sda_drv && prev_scl) sda_hi_moves++;
        end
        prev_sda_drv = sda_drv;
        prev_scl     = scl_line;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_byte_stat(bit mack, bit last);
        if (!mack) return 8'hC0;
        if (last)  return 8'hC8;
        return 8'hB8;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_scl();
        int guard = 0;
        m_scl_low = 1'b0;
        while (!scl_line && guard < 5000) begin tick(1); guard++; end
        if (guard >= 5000) check_eq("R7 SCL never released", 0, 1);
    endtask

    task automatic m_start();
        m_sda_low = 1'b1; tick(H);
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic m_stop();
        m_scl_low = 1'b1; tick(H);
        m_sda_low = 1'b1; tick(H);
        release_scl();    tick(H);
        m_sda_low = 1'b0; tick(H);
    endtask

    task automatic m_write_bit(input logic b);
        m_sda_low = !b; tick(H);
        release_scl();  tick(H);
        m_scl_low = 1'b1;
    endtask

    task automatic m_read_bit(output logic v);
        m_sda_low = 1'b0;
        release_scl(); tick(H);
        v = sda_line;
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic m_send_ack(input bit ack);
        m_sda_low = ack; tick(H);
        release_scl();   tick(H);
        m_scl_low = 1'b1; tick(H);
        m_sda_low = 1'b0;
    endtask

    task automatic sw_write(input logic [7:0] d, input bit aa, input bit sta);
        ctl_data = d; ctl_aa = aa; ctl_sta = sta; ctl_write = 1'b1;
        tick(1);
        ctl_write = 1'b0; ctl_sta = 1'b0;
    endtask

    task automatic stretch_check(input string req, input int exp_stat);
        m_scl_low = 1'b0;
        tick(10);
        check_eq("R7 SCL stretched while flag set", int'(scl_line), 0);
        check_eq({req, " flag raised"}, int'(irq), 1);
        check_eq({req, " status"}, int'(status), exp_stat);
    endtask

    // Address phase; returns whether the address was acknowledged
    task automatic m_address(input logic [6:0] a, input bit rd, input bit arb, output bit acked);
        logic [7:0] ab;
        ab = {a, rd};
        m_start();
        for (int k = 7; k >= 0; k--) begin
            if (arb && k == 5) begin arb_lost = 1'b1; tick(1); arb_lost = 1'b0; end
            m_write_bit(ab[k]);
        end
        m_sda_low = 1'b0; tick(H);
        release_scl(); tick(H);
        acked = !sda_line;
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic read_xfer(input logic [6:0] a, input bit rd, input int n, input int nack_at,
                             input bit arb, input bit exit_aa, input bit exit_sta);
        bit acked, exp_ack, fin;
        int go_before;
        exp_ack = rd && (a == OWN) && b_recog;
        m_address(a, rd, arb, acked);
        check_eq(exp_ack ? "R1 own read address acknowledged" : "R10/R8 address not acknowledged",
                 int'(acked), int'(exp_ack));
        if (!acked) begin
            tick(4);
            check_eq("R10/R8 no flag for unanswered address", int'(irq), 0);
            m_stop();
            return;
        end
        stretch_check(arb ? "R2 arbitration-lost read" : "R1 own read", arb ? 8'hB0 : 8'hA8);
        fin = 1'b0;
        for (int i = 0; i < n && !fin; i++) begin
            logic [7:0] d, got;
            bit last, mack;
            int es;
            d    = 8'($urandom);
            last = (i == n - 1);
            mack = (i != nack_at);
            sw_write(d, !last, 1'b0);
            for (int k = 7; k >= 0; k--) begin
                logic v;
                m_read_bit(v);
                got[k] = v;
            end
            check_eq("R3 byte seen MSB first", int'(got), int'(d));
            m_send_ack(mack);
            es = exp_byte_stat(mack, last);
            stretch_check(es == 8'hB8 ? "R4 acked byte" : es == 8'hC0 ? "R5 unacked byte" : "R6 acked last byte", es);
            fin = (es != 8'hB8);
        end
        go_before = go_count;
        sw_write(8'h00, exit_aa, exit_sta);
        b_recog = exit_aa;
        tick(2);
        check_eq("R7 flag cleared by write", int'(irq), 0);
        check_eq("R7 idle status", int'(status), 8'hF8);
        release_scl();
        tick(20);
        check_eq("R9 no START while bus busy", go_count, go_before);
        m_stop();
        tick(10);
        check_eq("R9 queued START after STOP", go_count, go_before + (exit_sta ? 1 : 0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        bit acked;
        logic v;
        seed_dummy = $urandom(32'h1C5E);
        tick(5);
        rst = 1'b0;
        tick(3);
        // R11 reset state
        check_eq("R11 reset flag", int'(irq), 0);
        check_eq("R11 reset status", int'(status), 8'hF8);
        check_eq("R11 reset SCL released", int'(scl_drv), 0);
        check_eq("R11 reset SDA released", int'(sda_drv), 0);

        // Directed: basic read of two bytes, master acks all
        read_xfer(OWN, 1'b1, 2, 2, 1'b0, 1'b1, 1'b0);
        // R5: master NACKs the first of three
        read_xfer(OWN, 1'b1, 3, 0, 1'b0, 1'b1, 1'b0);
        // R2 arbitration lost, then R9 START queued
        read_xfer(OWN, 1'b1, 1, 1, 1'b1, 1'b1, 1'b1);
        // R10 wrong address and write direction
        read_xfer(7'h15, 1'b1, 1, 1, 1'b0, 1'b1, 1'b0);
        read_xfer(OWN, 1'b0, 1, 1, 1'b0, 1'b1, 1'b0);
        // R8 exit with AA=0 disables recognition
        read_xfer(OWN, 1'b1, 1, 0, 1'b0, 1'b0, 1'b0);
        read_xfer(OWN, 1'b1, 1, 1, 1'b0, 1'b1, 1'b0);
        // R12 idle write re-enables, then disables, then re-enables
        sw_write(8'h00, 1'b1, 1'b0); b_recog = 1'b1; tick(2);
        check_eq("R12 idle write leaves flag clear", int'(irq), 0);
        read_xfer(OWN, 1'b1, 1, 1, 1'b0, 1'b1, 1'b0);
        sw_write(8'h00, 1'b0, 1'b0); b_recog = 1'b0; tick(2);
        read_xfer(OWN, 1'b1, 1, 1, 1'b0, 1'b1, 1'b0);
        sw_write(8'h00, 1'b1, 1'b0); b_recog = 1'b1; tick(2);

        // R11 STOP in the middle of a byte
        m_address(OWN, 1'b1, 1'b0, acked);
        check_eq("R1 address acked before mid-byte STOP", int'(acked), 1);
        stretch_check("R1 own read", 8'hA8);
        sw_write(8'hFF, 1'b1, 1'b0);
        m_read_bit(v);
        check_eq("R3 first bit of 0xFF", int'(v), 1);
        m_sda_low = 1'b1; tick(H);
        release_scl(); tick(H);
        m_sda_low = 1'b0; tick(H);
        check_eq("R11 SDA released after STOP", int'(sda_drv), 0);
        check_eq("R11 flag clear after STOP", int'(irq), 0);
        begin
            int drv_seen = 0;
            for (int p = 0; p < 9; p++) begin
                m_scl_low = 1'b1; tick(H);
                if (sda_drv) drv_seen++;
                release_scl(); tick(H);
                if (sda_drv) drv_seen++;
            end
            check_eq("R11 no SDA drive after STOP", drv_seen, 0);
        end

        // Random transfers
        for (int t = 0; t < 14; t++) begin
            int n, na;
            n  = 1 + int'($urandom_range(3));
            na = int'($urandom_range(n));
            read_xfer(OWN, 1'b1, n, na, 1'($urandom_range(1)), 1'b1, 1'($urandom_range(1)));
        end

        check_eq("R3 SDA moved while SCL high", sda_hi_moves, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule